// File: doc/BRIEF.md
# Comparator Control and Interrupt Register

This block is the digital face of an on-chip analog comparator. It holds one 8-bit register reached through a small bus: an address-hit qualifier, a write strobe, write data and read data. The block drives the comparator's power-down, reference-select and negative-input-select controls from that register. It also brings the comparator's raw, asynchronous output into the clock domain through a short synchronizer chain and shows the result as a read-only status bit.

The synchronized output feeds an edge detector. A two-bit trigger mode chooses which edges count as events. An event sets a sticky interrupt flag. Software clears the flag by writing a one to its bit, and the interrupt controller clears it by pulsing an acknowledge when it takes the vector. The interrupt request is raised only while the flag, the local enable and the global interrupt bit are all set. While the comparator is powered down, the synchronizer history is frozen and no event is detected.

Top module: `cmp_ctrl_reg`

## Requirements
- R1: After reset, every register bit is zero. With the address hit high, the read data is 0x00 and irqReq, pwrDown, refSel and negSelMux are all low.
- R2: A write (selHit and wrEn high) loads the configuration bits: bit 7 disable, bit 6 reference select, bit 3 interrupt enable, bit 2 mux enable and bits 1:0 trigger mode. Reading them back returns the written values. The read data is 0x00 while selHit is low.
- R3: Bit 5 is the read-only comparator status. Writing a one or a zero to it has no effect.
- R4: With the comparator enabled, bit 5 follows cmpRaw after two clock edges: it is still old after the first edge and new after the second.
- R5: The trigger mode sets which edges count. 00 is any toggle, 01 means no events, 10 is a falling edge and 11 is a rising edge. A qualifying event sets flag bit 4 on the clock edge after the status bit changes.
- R6: Writing a one to bit 4 clears the flag. Writing a zero to bit 4 leaves the flag unchanged.
- R7: A one-cycle vecAck pulse clears the flag.
- R8: If an event and a clear (a write-one or vecAck) fall in the same cycle, the flag is set.
- R9: irqReq is high exactly while the flag, the interrupt enable bit and globalIe are all high.
- R10: negSelMux is high only when the mux enable bit is one and adcOn is low.
- R11: pwrDown equals the disable bit and refSel equals the reference-select bit. Both change only on a register write.
- R12: While disable is one, the status bit holds its value and no event sets the flag. Re-enabling with an unchanged comparator input raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selHit | input | 1 | Address decode hit for this register |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (zero when not selected) |
| cmpRaw | input | 1 | Asynchronous comparator output |
| globalIe | input | 1 | Global interrupt enable |
| adcOn | input | 1 | ADC enabled; blocks the mux override |
| vecAck | input | 1 | Interrupt vector taken; clears the flag |
| irqReq | output | 1 | Interrupt request |
| pwrDown | output | 1 | Comparator power-down |
| refSel | output | 1 | Select the internal reference as the positive input |
| negSelMux | output | 1 | Select the ADC multiplexer as the negative input |

## Verification
The checker watches, on every cycle, the gating of the interrupt request, the lockout of the mux override while the ADC is on, flag retention when no clear is present, stability of the control outputs between writes, and the frozen status and suppressed flag while powered down. Only the bench scenarios can show the two-edge status latency, the choice of edge under each trigger mode, the set-over-clear priority in a shared cycle, the read-only status bit, and the absence of a spurious flag when the comparator is re-enabled.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_DIS  = 7;
  localparam int BIT_REF  = 6;
  localparam int BIT_STAT = 5;
  localparam int BIT_FLAG = 4;
  localparam int BIT_IE   = 3;
  localparam int BIT_MUX  = 2;

  typedef enum logic [1:0] {
    TRIG_ANY  = 2'b00,
    TRIG_NONE = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  typedef struct packed {
    logic  cfgWr;
    logic  flagClr;
    logic  dis;
    logic  refSel;
    logic  ie;
    logic  mux;
    trig_e trig;
  } ctl_strobe_t;
endpackage

// File: rtl/cmp_ctrl_ctl.sv
module cmp_ctrl_ctl
  import cmp_ctrl_pkg::*;
(
  input  logic             selHit,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             vecAck,
  output ctl_strobe_t      strb
);
  logic wrHit;
  logic unusedStatusWr;

  assign wrHit          = selHit & wrEn;
  assign unusedStatusWr = wrData[BIT_STAT];

  always_comb begin
    strb.cfgWr   = wrHit;
    strb.flagClr = vecAck | (wrHit & wrData[BIT_FLAG]);
    strb.dis     = wrData[BIT_DIS];
    strb.refSel  = wrData[BIT_REF];
    strb.ie      = wrData[BIT_IE];
    strb.mux     = wrData[BIT_MUX];
    strb.trig    = trig_e'(wrData[1:0]);
  end
endmodule

// File: rtl/cmp_ctrl_dp.sv
module cmp_ctrl_dp
  import cmp_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobe_t      strb,
  input  logic             cmpRaw,
  input  logic             selHit,
  input  logic             globalIe,
  input  logic             adcOn,
  output logic [REG_W-1:0] rdData,
  output logic             irqReq,
  output logic             pwrDown,
  output logic             refSel,
  output logic             negSelMux,
  output logic             flagQ,
  output logic             statusQ
);
  localparam int LAST = SYNC_STAGES - 1;

  logic                   disQ, refQ, ieQ, muxQ;
  trig_e                  trigQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   histQ;
  logic                   riseEv, fallEv, evHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disQ  <= 1'b0;
      refQ  <= 1'b0;
      ieQ   <= 1'b0;
      muxQ  <= 1'b0;
      trigQ <= TRIG_ANY;
    end else if (strb.cfgWr) begin
      disQ  <= strb.dis;
      refQ  <= strb.refSel;
      ieQ   <= strb.ie;
      muxQ  <= strb.mux;
      trigQ <= strb.trig;
    end
  end

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    logic dIn;
    if (g == 0) begin : gFirst
      assign dIn = cmpRaw;
    end else begin : gNext
      assign dIn = syncQ[g-1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      syncQ[g] <= 1'b0;
      else if (!disQ) syncQ[g] <= dIn;
    end
  end

  assign statusQ = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      histQ <= 1'b0;
    else if (!disQ) histQ <= statusQ;
  end

  assign riseEv = statusQ & ~histQ;
  assign fallEv = ~statusQ & histQ;

  always_comb begin
    unique case (trigQ)
      TRIG_ANY:  evHit = riseEv | fallEv;
      TRIG_NONE: evHit = 1'b0;
      TRIG_FALL: evHit = fallEv;
      TRIG_RISE: evHit = riseEv;
      default:   evHit = 1'b0;
    endcase
    evHit = evHit & ~disQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             flagQ <= 1'b0;
    else if (evHit)        flagQ <= 1'b1;
    else if (strb.flagClr) flagQ <= 1'b0;
  end

  assign rdData    = selHit ? {disQ, refQ, statusQ, flagQ, ieQ, muxQ, trigQ} : '0;
  assign irqReq    = flagQ & ieQ & globalIe;
  assign pwrDown   = disQ;
  assign refSel    = refQ;
  assign negSelMux = muxQ & ~adcOn;
endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
  import cmp_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selHit,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       cmpRaw,
  input  logic       globalIe,
  input  logic       adcOn,
  input  logic       vecAck,
  output logic       irqReq,
  output logic       pwrDown,
  output logic       refSel,
  output logic       negSelMux
);
  ctl_strobe_t strb;
  logic        flagQ;
  logic        statusQ;

  cmp_ctrl_ctl i_ctl (
    .selHit (selHit),
    .wrEn   (wrEn),
    .wrData (wrData),
    .vecAck (vecAck),
    .strb   (strb)
  );

  cmp_ctrl_dp #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmpRaw    (cmpRaw),
    .selHit    (selHit),
    .globalIe  (globalIe),
    .adcOn     (adcOn),
    .rdData    (rdData),
    .irqReq    (irqReq),
    .pwrDown   (pwrDown),
    .refSel    (refSel),
    .negSelMux (negSelMux),
    .flagQ     (flagQ),
    .statusQ   (statusQ)
  );
endmodule

// File: rtl/cmp_ctrl_chk.sv
module cmp_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       selHit,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       globalIe,
  input logic       adcOn,
  input logic       vecAck,
  input logic       irqReq,
  input logic       pwrDown,
  input logic       refSel,
  input logic       negSelMux,
  input logic       flagQ,
  input logic       statusQ
);
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (globalIe && flagQ));

  assert_negsel_lock_R10: assert property (@(posedge clk) disable iff (!rstN)
    negSelMux |-> !adcOn);

  assert_flag_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !vecAck && !(selHit && wrEn && wrData[4])) |=> flagQ);

  assert_ctrl_steady_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(selHit && wrEn) |=> ($stable(pwrDown) && $stable(refSel)));

  assert_status_frozen_R12: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> $stable(statusQ));

  assert_no_event_off_R12: assert property (@(posedge clk) disable iff (!rstN)
    (pwrDown && !flagQ) |=> !flagQ);
endmodule

bind cmp_ctrl_reg cmp_ctrl_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .selHit    (selHit),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .globalIe  (globalIe),
  .adcOn     (adcOn),
  .vecAck    (vecAck),
  .irqReq    (irqReq),
  .pwrDown   (pwrDown),
  .refSel    (refSel),
  .negSelMux (negSelMux),
  .flagQ     (flagQ),
  .statusQ   (statusQ)
);

// File: tb/test_cmp_ctrl_reg.sv
module test_cmp_ctrl_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selHit = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       cmpRaw = 1'b0;
  logic       globalIe = 1'b0;
  logic       adcOn = 1'b0;
  logic       vecAck = 1'b0;
  logic       irqReq, pwrDown, refSel, negSelMux;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [11:0] val;
    logic [11:0] mask;
    string       req;
  } item_t;
  item_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_ctrl_reg i_cmp_ctrl_reg (
    .clk(clk), .rstN(rstN), .selHit(selHit), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cmpRaw(cmpRaw), .globalIe(globalIe), .adcOn(adcOn),
    .vecAck(vecAck), .irqReq(irqReq), .pwrDown(pwrDown), .refSel(refSel),
    .negSelMux(negSelMux)
  );

  wire [11:0] obs = {rdData, irqReq, pwrDown, refSel, negSelMux};

  // monitor: compares the oldest expected item with the outputs at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      total++;
      if ((obs & it.mask) !== (it.val & it.mask)) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h (mask %h)", it.req, obs, it.val, it.mask);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    step();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic expAll(input logic [11:0] v, input string req);
    item_t it;
    it.val = v; it.mask = 12'hFFF; it.req = req;
    expQ.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expRd(input logic [7:0] v, input string req);
    item_t it;
    it.val = {v, 4'h0}; it.mask = 12'hFF0; it.req = req;
    expQ.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step();
    expAll(12'h000, "R1 reset");
    rstN = 1'b1;
    step();
    expAll(12'h000, "R1 after reset");

    // R2 R3 R11 R10: all ones; status stays 0, flag write-one clears nothing
    wr(8'hFF);
    expAll({8'hCF, 1'b0, 1'b1, 1'b1, 1'b1}, "R2 R3 R11 R10 write FF");
    adcOn = 1'b1; step();
    expAll({8'hCF, 1'b0, 1'b1, 1'b1, 1'b0}, "R10 adc on blocks mux");
    adcOn = 1'b0;
    wr(8'h04);
    selHit = 1'b0; step();
    expAll({8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, "R2 no select reads zero");
    selHit = 1'b1;

    // R4 R5 toggle mode with interrupts
    wr(8'h08);
    globalIe = 1'b1;
    cmpRaw = 1'b1;
    step();
    expRd(8'h08, "R4 one edge still old");
    step();
    expAll({8'h28, 4'b0000}, "R4 two edges status new");
    step();
    expAll({8'h38, 4'b1000}, "R5 R9 toggle rise sets flag irq");
    globalIe = 1'b0; step();
    expAll({8'h38, 4'b0000}, "R9 global off drops irq");

    // R6
    wr(8'h08);
    expRd(8'h38, "R6 write zero keeps flag");
    wr(8'h18);
    expRd(8'h28, "R6 write one clears flag");

    // R7: falling toggle then acknowledge
    cmpRaw = 1'b0; steps(3);
    expRd(8'h18, "R5 toggle fall sets flag");
    vecAck = 1'b1; step(); vecAck = 1'b0;
    expRd(8'h08, "R7 ack clears flag");

    // R5 mode 01: no events
    wr(8'h09);
    cmpRaw = 1'b1; steps(4);
    expRd(8'h29, "R5 mode 01 no event");

    // R5 mode 10 falling
    wr(8'h0A);
    cmpRaw = 1'b0; steps(4);
    expRd(8'h1A, "R5 falling mode on fall");
    wr(8'h1A);
    cmpRaw = 1'b1; steps(4);
    expRd(8'h2A, "R5 falling mode ignores rise");

    // R5 mode 11 rising
    wr(8'h0B);
    cmpRaw = 1'b0; steps(4);
    expRd(8'h0B, "R5 rising mode ignores fall");
    cmpRaw = 1'b1; steps(4);
    expRd(8'h3B, "R5 rising mode on rise");

    // R8: event and clear in the same cycle
    wr(8'h18);
    expRd(8'h28, "R8 setup clear");
    cmpRaw = 1'b0; steps(2);
    vecAck = 1'b1; wr(8'h18); vecAck = 1'b0;
    expRd(8'h18, "R8 set wins over clear");

    // R12: disable freezes and suppresses
    wr(8'h18);
    wr(8'h88);
    expAll({8'h88, 4'b0100}, "R12 R11 disabled");
    cmpRaw = 1'b1; steps(4);
    expRd(8'h88, "R12 frozen no flag");
    cmpRaw = 1'b0; steps(3);
    wr(8'h08); steps(4);
    expAll({8'h08, 4'b0000}, "R12 re-enable no spurious flag");

    done = 1'b1;
    steps(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule